// File: doc/BRIEF.md
# DMA Request Handshake Sequencer

This block is the device-side request logic that a network controller with local buffer RAM uses to move data over a system DMA channel. Software arms it by writing the low byte of the buffer address pointer. After a short settling delay measured in arbitration-clock periods, the block raises its request. It then follows the host controller's acknowledge and strobe handshake until terminal count finishes the transfer.

Two pacing modes are supported. In single-transfer mode the request falls on every accepted read or write strobe and returns as soon as that strobe ends. In burst mode the host keeps the acknowledge low across many strobes. A gate timer measures how long the acknowledge has been held. Once the host has released the channel, the request comes back in one of two ways: after a fixed number of crystal periods if the gate timer had expired, or when a well-formed refresh-pause edge arrives.

The block also watches for the forbidden overlap of acknowledge and refresh-pause and raises a sticky flag when it sees it.

Top module: `dma_req_seq`

## Requirements
- R1: After reset, `dreq`, `done` and `proto_err` are 0. No request is raised until a pointer write, whatever ticks or strobes arrive in the meantime.
- R2: With `slow_arb`=0 every `op_tick` is an arbitration tick. `dreq` rises in the cycle after the fourth arbitration tick sampled after the `ptr_lo_wr` cycle. A tick in the pointer-write cycle itself does not count.
- R3: With `slow_arb`=1 only every second `op_tick` after the pointer write is an arbitration tick. Otherwise the rule of R2 applies.
- R4: A strobe (`rd_n`=0 or `wr_n`=0) sampled while `dack_n`=0 and `dreq`=1 makes `dreq` 0 in the next cycle.
- R5: A strobe sampled together with `tc`=1 while `dack_n`=0 makes `dreq` 0 and `done` 1 in the next cycle. `done` then holds and no request is raised until the next pointer write, which clears `done`.
- R6: In single-transfer mode (`burst_en`=0), `dreq` returns to 1 in the cycle after the strobe is sampled inactive.
- R7: Strobes sampled while `dack_n`=1 leave `dreq` unchanged.
- R8: In burst mode (`burst_en`=1), `dreq` stays 0 while `dack_n` is held low. The gate timer counts `xtal_tick` while `dack_n`=0 and expires at GATE_TICKS (default 32) ticks. If `dack_n` rises after expiry, `dreq` rises in the cycle after the 8th `xtal_tick` (`gate_long`=0) or the 16th `xtal_tick` (`gate_long`=1) sampled after the release.
- R9: In burst mode, after a release without gate expiry, no timed re-request occurs. `dreq` rises in the cycle after a falling edge of `refex_n`, but only if `refex_n` had been high for at least 3 `xtal_tick`s. A fall after a shorter high time is ignored.
- R10: `dack_n`=0 and `refex_n`=0 sampled in the same cycle set `proto_err` in the next cycle. It stays set until a pointer write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xtal_tick | input | 1 | One-cycle pulse per crystal period |
| op_tick | input | 1 | One-cycle pulse per operation-clock period |
| slow_arb | input | 1 | 1: arbitration clock is half the operation clock |
| burst_en | input | 1 | 1: programmable burst mode, 0: single-transfer mode |
| gate_long | input | 1 | Burst re-request delay select: 0 = 8, 1 = 16 crystal ticks |
| ptr_lo_wr | input | 1 | Pulse: low address pointer byte written |
| dack_n | input | 1 | DMA acknowledge, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| tc | input | 1 | Terminal count, active high |
| refex_n | input | 1 | Refresh-pause input, active low |
| dreq | output | 1 | DMA request, registered |
| done | output | 1 | Transfer ended by terminal count, registered |
| proto_err | output | 1 | Sticky flag: acknowledge and refresh-pause overlapped |

## Verification
The bench counts arbitration ticks with sparse and halved operation ticks. A pacer that counted the pointer-write cycle, or that did not halve its rate, would raise the request one or more cycles off. It drives strobes with the acknowledge high, where a design that failed to qualify strobes would drop the request. It holds strobes after terminal count, where a design that did not latch completion would start requesting again. In burst mode it releases the acknowledge both before and after gate expiry and checks the 8- and 16-tick delays to the exact cycle. It also sends a refresh-pause edge after only two high ticks; a guard that counted wrongly would re-request early or never re-request at all.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_START,
    SEQ_REQ,
    SEQ_XFER,
    SEQ_PAUSE,
    SEQ_DONE
  } seq_state_t;

endpackage

// File: rtl/dma_arb_pacer.sv
module dma_arb_pacer (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic op_tick,
  input  logic slow_arb,
  output logic arb_tick
);
  logic phase;

  always_ff @(posedge clk) begin
    if (rst || restart) phase <= 1'b0;
    else if (op_tick)   phase <= ~phase;
  end

  assign arb_tick = op_tick && !restart && (!slow_arb || phase);
endmodule

// File: rtl/dma_gate_timer.sv
module dma_gate_timer #(
  parameter int GATE_TICKS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic xtal_tick,
  output logic expired
);
  localparam int CNT_W = $clog2(GATE_TICKS + 1);
  logic [CNT_W-1:0] cnt;

  assign expired = (cnt == CNT_W'(GATE_TICKS));

  always_ff @(posedge clk) begin
    if (rst || !run)             cnt <= '0;
    else if (xtal_tick && !expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dma_refex_qual.sv
module dma_refex_qual #(
  parameter int MIN_HI = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic refex_n,
  input  logic xtal_tick,
  output logic fall_ok
);
  localparam int HI_W = $clog2(MIN_HI + 1);
  logic [HI_W-1:0] hi_cnt;
  logic            ref_q;

  assign fall_ok = !refex_n && ref_q && (hi_cnt >= HI_W'(MIN_HI));

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0;
      ref_q  <= 1'b0;
    end else begin
      ref_q <= refex_n;
      if (!refex_n)                                     hi_cnt <= '0;
      else if (xtal_tick && hi_cnt < HI_W'(MIN_HI))     hi_cnt <= hi_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dma_req_seq.sv
module dma_req_seq
  import dma_req_pkg::*;
#(
  parameter int START_ARB  = 4,
  parameter int GATE_TICKS = 32,
  parameter int DLY_SHORT  = 8,
  parameter int DLY_LONG   = 16,
  parameter int REFEX_HI   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic xtal_tick,
  input  logic op_tick,
  input  logic slow_arb,
  input  logic burst_en,
  input  logic gate_long,
  input  logic ptr_lo_wr,
  input  logic dack_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic tc,
  input  logic refex_n,
  output logic dreq,
  output logic done,
  output logic proto_err
);
  localparam int ARB_W = $clog2(START_ARB);
  localparam int DLY_W = $clog2(DLY_LONG + 1);

  seq_state_t       state;
  logic [ARB_W-1:0] arb_cnt;
  logic [DLY_W-1:0] dly;
  logic [DLY_W-1:0] dly_lim;
  logic             exp_q;
  logic             arb_tick, gate_exp, ref_ok;
  logic             strb, acc;

  assign strb    = !rd_n || !wr_n;
  assign acc     = strb && !dack_n;
  assign dly_lim = gate_long ? DLY_W'(DLY_LONG) : DLY_W'(DLY_SHORT);

  dma_arb_pacer u_pacer (
    .clk      (clk),
    .rst      (rst),
    .restart  (ptr_lo_wr),
    .op_tick  (op_tick),
    .slow_arb (slow_arb),
    .arb_tick (arb_tick)
  );

  dma_gate_timer #(.GATE_TICKS(GATE_TICKS)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .run       (burst_en && !dack_n),
    .xtal_tick (xtal_tick),
    .expired   (gate_exp)
  );

  dma_refex_qual #(.MIN_HI(REFEX_HI)) u_refex (
    .clk       (clk),
    .rst       (rst),
    .refex_n   (refex_n),
    .xtal_tick (xtal_tick),
    .fall_ok   (ref_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      dreq      <= 1'b0;
      done      <= 1'b0;
      proto_err <= 1'b0;
      arb_cnt   <= '0;
      dly       <= '0;
      exp_q     <= 1'b0;
    end else if (ptr_lo_wr) begin
      state     <= SEQ_START;
      dreq      <= 1'b0;
      done      <= 1'b0;
      proto_err <= 1'b0;
      arb_cnt   <= '0;
      dly       <= '0;
      exp_q     <= 1'b0;
    end else begin
      if (!dack_n && !refex_n) proto_err <= 1'b1;
      case (state)
        SEQ_START: begin
          if (arb_tick) begin
            if (arb_cnt == ARB_W'(START_ARB - 1)) begin
              state <= SEQ_REQ;
              dreq  <= 1'b1;
            end else begin
              arb_cnt <= arb_cnt + 1'b1;
            end
          end
        end
        SEQ_REQ: begin
          if (acc) begin
            dreq <= 1'b0;
            if (tc) begin
              done  <= 1'b1;
              state <= SEQ_DONE;
            end else begin
              state <= SEQ_XFER;
            end
          end
        end
        SEQ_XFER: begin
          if (acc && tc) begin
            done  <= 1'b1;
            state <= SEQ_DONE;
          end else if (burst_en) begin
            if (dack_n) begin
              state <= SEQ_PAUSE;
              exp_q <= gate_exp;
              dly   <= '0;
            end
          end else if (!strb) begin
            state <= SEQ_REQ;
            dreq  <= 1'b1;
          end
        end
        SEQ_PAUSE: begin
          if (ref_ok || (exp_q && xtal_tick && dly == dly_lim - DLY_W'(1))) begin
            state <= SEQ_REQ;
            dreq  <= 1'b1;
          end else if (exp_q && xtal_tick) begin
            dly <= dly + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dma_req_seq_chk.sv
module dma_req_seq_chk (
  input logic clk,
  input logic rst,
  input logic ptr_lo_wr,
  input logic dack_n,
  input logic rd_n,
  input logic wr_n,
  input logic refex_n,
  input logic dreq,
  input logic done,
  input logic proto_err
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!dreq && !done && !proto_err)); // R1

  AST_STROBE_DROPS: assert property (@(posedge clk) disable iff (rst)
    (dreq && !dack_n && (!rd_n || !wr_n) && !ptr_lo_wr) |=> !dreq); // R4

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (done && !ptr_lo_wr) |=> (done && !dreq)); // R5

  AST_DACK_HIGH_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (dreq && dack_n && !ptr_lo_wr) |=> dreq); // R7

  AST_ERR_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!dack_n && !refex_n && !ptr_lo_wr) |=> proto_err); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (proto_err && !ptr_lo_wr) |=> proto_err); // R10
endmodule

bind dma_req_seq dma_req_seq_chk u_chk (.*);

// File: tb/sim_dma_req_seq.sv
module sim_dma_req_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic xtal_tick = 0, op_tick = 0, slow_arb = 0, burst_en = 0, gate_long = 0;
  logic ptr_lo_wr = 0, dack_n = 1, rd_n = 1, wr_n = 1, tc = 0, refex_n = 1;
  logic dreq, done, proto_err;
  int   cyc = 0;
  int   n_chk = 0, n_fail = 0;

  typedef struct {
    int         at;
    logic [2:0] v;
    string      tag;
  } exp_t;
  exp_t       q[$];
  logic [2:0] model = 3'b000;
  logic [2:0] prev  = 3'b000;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dma_req_seq u0 (.*);

  // Monitor: every change of {dreq,done,proto_err} must match the queue head.
  always @(negedge clk) begin
    if (!rst) begin
      logic [2:0] cur;
      cur = {dreq, done, proto_err};
      if (cur !== prev) begin
        n_chk++;
        if (q.size() == 0) begin
          n_fail++;
          $display("FAIL unexpected change at cyc=%0d: got %b, expected no change (R7/R8/R9)", cyc, cur);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.at != cyc || e.v !== cur) begin
            n_fail++;
            $display("FAIL %s: got cyc=%0d {dreq,done,err}=%b, expected cyc=%0d %b",
                     e.tag, cyc, cur, e.at, e.v);
          end
        end
      end
      prev = cur;
    end
  end

  task automatic xp(input int at, input logic d, input logic dn, input logic er, input string tag);
    if ({d, dn, er} !== model) begin
      exp_t e;
      e.at = at; e.v = {d, dn, er}; e.tag = tag;
      q.push_back(e);
      model = {d, dn, er};
    end
  endtask

  task automatic tick(input logic xt = 0, input logic op = 0);
    xtal_tick = xt;
    op_tick   = op;
    @(negedge clk);
    xtal_tick = 0;
    op_tick   = 0;
  endtask

  task automatic check_out(input string tag, input logic [2:0] want);
    n_chk++;
    if ({dreq, done, proto_err} !== want) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, {dreq, done, proto_err}, want);
    end
  endtask

  // Pointer write, then op ticks every 'gap' cycles; model counts arbitration ticks.
  task automatic pace(input logic slow, input int gap, input string tag);
    int nop = 0, na = 0, k = 0;
    slow_arb  = slow;
    ptr_lo_wr = 1;
    xp(cyc + 1, 0, 0, 0, tag);
    tick(0, 1);
    ptr_lo_wr = 0;
    while (na < 4) begin
      logic op;
      op = ((k % gap) == gap - 1);
      k++;
      if (op) begin
        nop++;
        if (!slow || (nop % 2 == 0)) na++;
      end
      if (na == 4) xp(cyc + 1, 1, 0, 0, tag);
      tick(0, op);
    end
    tick();
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: got hang, expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check_out("R1 reset state", 3'b000);

    // R1: ticks and acknowledged strobes before any pointer write
    dack_n = 0;
    for (int i = 0; i < 10; i++) begin
      rd_n = i[0];
      tick(1, 1);
    end
    rd_n = 1; dack_n = 1;
    tick();
    check_out("R1 idle without pointer write", 3'b000);

    // R2: fast arbitration, op tick every cycle
    burst_en = 0;
    pace(0, 1, "R2 first request");

    // R4 / R6: single-transfer read
    dack_n = 0; tick();
    rd_n = 0; xp(cyc + 1, 0, 0, 0, "R4 read drop"); tick(); tick();
    rd_n = 1; xp(cyc + 1, 1, 0, 0, "R6 re-request"); tick();

    // R7: strobes with acknowledge high
    dack_n = 1;
    wr_n = 0; tick(); tick(); tick();
    wr_n = 1; tick();
    check_out("R7 strobe ignored", 3'b100);

    // R4 / R6: write strobe
    dack_n = 0; tick();
    wr_n = 0; xp(cyc + 1, 0, 0, 0, "R4 write drop"); tick();
    wr_n = 1; xp(cyc + 1, 1, 0, 0, "R6 re-request after write"); tick();

    // R5: terminal count
    wr_n = 0; tc = 1; xp(cyc + 1, 0, 1, 0, "R5 terminal count"); tick();
    wr_n = 1; tc = 0; tick(); tick();
    rd_n = 0; tick(); tick();
    rd_n = 1; tick(); tick();
    dack_n = 1; tick();
    check_out("R5 done holds", 3'b010);

    // R3: slow arbitration, also clears done
    pace(1, 1, "R3 slow arbitration");
    // R2: sparse op ticks
    pace(0, 3, "R2 sparse op ticks");

    // R8: burst, short delay
    burst_en = 1; gate_long = 0;
    pace(0, 1, "R8 burst start");
    dack_n = 0; tick();
    rd_n = 0; xp(cyc + 1, 0, 0, 0, "R4 burst drop"); tick();
    for (int i = 0; i < 40; i++) begin
      rd_n = i[0];
      tick(1, 0);
    end
    rd_n = 1; dack_n = 1; tick();
    for (int i = 1; i <= 8; i++) begin
      tick();
      if (i == 8) xp(cyc + 1, 1, 0, 0, "R8 short delay");
      tick(1, 0);
    end
    tick();

    // R8: burst, long delay
    gate_long = 1;
    dack_n = 0; tick();
    wr_n = 0; xp(cyc + 1, 0, 0, 0, "R4 burst write drop"); tick();
    wr_n = 1;
    for (int i = 0; i < 40; i++) tick(1, 0);
    dack_n = 1; tick();
    for (int i = 1; i <= 16; i++) begin
      if (i == 16) xp(cyc + 1, 1, 0, 0, "R8 long delay");
      tick(1, 0);
    end
    tick();

    // R9: release before expiry, refresh-pause re-arm
    dack_n = 0; tick();
    rd_n = 0; xp(cyc + 1, 0, 0, 0, "R4 burst short hold"); tick();
    rd_n = 1;
    for (int i = 0; i < 5; i++) tick(1, 0);
    dack_n = 1; refex_n = 0; tick();
    for (int i = 0; i < 20; i++) tick(1, 0);
    refex_n = 1; tick(1, 0); tick(1, 0);
    refex_n = 0; tick(); tick();
    check_out("R9 short high time ignored", 3'b000);
    refex_n = 1; tick(1, 0); tick(1, 0); tick(1, 0);
    refex_n = 0; xp(cyc + 1, 1, 0, 0, "R9 refresh re-arm"); tick();
    refex_n = 1; tick(); tick();

    // R10: acknowledge and refresh-pause overlap
    dack_n = 0; refex_n = 0; xp(cyc + 1, 1, 0, 1, "R10 overlap flagged"); tick();
    refex_n = 1; dack_n = 1; tick(); tick(); tick();
    check_out("R10 flag sticky", 3'b101);
    burst_en = 0;
    pace(0, 1, "R10 cleared by pointer write");

    repeat (5) tick();
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++; n_fail++;
      $display("FAIL %s: got no change, expected cyc=%0d %b", e.tag, e.at, e.v);
    end
    report();
    $finish;
  end
endmodule